// File: doc/BRIEF.md
# Data Address Translation Fault Checker

This block sits after the data-side translation lookup in a load/store pipeline. It takes the virtual address of one access and decides what physical address the access may use, whether that address bypasses the caches, and which fault (if any) the access must take. Its other inputs are the result of an already-performed lookup in the translation buffer: a hit flag, a page frame number, per-mode read and write enable masks, and two "trap on access" bits.

Every access runs through a fixed priority chain, and the first failing check decides the outcome. The checks are: natural alignment; the physical-bypass path; legality of the virtual address; a kernel-only direct-mapped window at the top of the address space; lookup miss; per-mode permission; trap-on-access bits; implemented physical width; and the uncached / internal-register region. The decision is registered, so results appear one clock after the inputs.

Top module: `dtc_xlate_check`

## Requirements
- R1: While reset is held, pa_o is zero, uncached_o is 0, fault_o is 0 (none) and status_o is zero.
- R2: If va_i AND (2^size_i − 1) is nonzero, the access takes fault code 1 (alignment) ahead of every other check. status_o bit 0 (write) equals write_i and no other status bit is set.
- R3: The permission-checking mode is alt_mode_i when priv_i and alt_i are both 1. It is kernel (0) when priv_i is 1 and alt_i is 0, and it is cur_mode_i when priv_i is 0. Mode codes are 0 kernel, 1 executive, 2 supervisor, 3 user.
- R4: With phys_i set, the physical address is va_i itself and the lookup result (hit, masks, trap bits) is ignored.
- R5: A non-bypass virtual address whose bits 63:43 are not all copies of bit 42 takes fault code 3 (page fault). Status bits 2 (bad address) and 1 (violation) are set, plus bit 0 when writing.
- R6: A valid address with bits 47:41 equal to 7'h7e is in the direct-mapped window. It is legal only when cur_mode_i is kernel (the alternate mode does not apply). Otherwise it takes fault code 2 (access violation) with status bit 1, plus bit 0 when writing.
- R7: A legal window access uses va_i[43:0]. If bit 40 of that value is 1, bits 43:40 are forced to 1. If bit 40 is 0, the address is cut to its low 40 bits.
- R8: A lookup miss sets status bit 3 (miss) plus bit 0 when writing. The fault code is 4 (primary miss) when pte_i is 1 and 5 (normal miss) otherwise.
- R9: On a hit the physical address is ppn_i × 2^13 plus va_i[12:0]. Access is allowed when the bit of wr_en_i (for a store) or rd_en_i (for a load) indexed by the effective mode is set.
- R10: A denied store takes fault code 3 with status bits 0 and 1, plus bit 5 if fonw_i is set. A denied load takes fault code 2 with status bit 1, plus bit 4 if fonr_i is set.
- R11: A permitted store with fonw_i set takes fault code 3 with status bits 0 and 5. A permitted load with fonr_i set takes fault code 3 with status bit 4.
- R12: If the resulting physical address has any bit at or above bit 44 set, the access takes fault code 6 (machine check) with status zero.
- R13: If physical bit 43 is set and bits 42:35 are all ones, the access takes fault code 7 (unimplemented) with status zero. If bit 43 is set otherwise, uncached_o is 1 and bits 42:35 of pa_o are cleared.
- R14: Outputs appear on the clock edge after the inputs. Whenever fault_o is not 0, pa_o is zero and uncached_o is 0. Status bit map: 0 write, 1 violation, 2 bad address, 3 miss, 4 trap-on-read, 5 trap-on-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| va_i | input | 64 | Virtual address of the access |
| size_i | input | 2 | Access size as log2 of bytes |
| write_i | input | 1 | 1 for a store, 0 for a load |
| phys_i | input | 1 | Physical bypass: use the address untranslated |
| alt_i | input | 1 | Use the alternate mode when in privileged code |
| pte_i | input | 1 | The access fetches a page table entry |
| priv_i | input | 1 | The access comes from privileged code |
| cur_mode_i | input | 2 | Current processor mode |
| alt_mode_i | input | 2 | Alternate mode |
| hit_i | input | 1 | Lookup hit |
| ppn_i | input | 32 | Page frame number from the lookup |
| rd_en_i | input | 4 | Per-mode load enable mask |
| wr_en_i | input | 4 | Per-mode store enable mask |
| fonr_i | input | 1 | Entry traps every load |
| fonw_i | input | 1 | Entry traps every store |
| pa_o | output | 44 | Physical address, zero on a fault |
| uncached_o | output | 1 | Access bypasses the caches |
| fault_o | output | 3 | Fault code |
| status_o | output | 6 | Fault status bits |

## Verification
The hardest outcomes to reach are the ones at the end of the priority chain: the internal-register fault and the uncached address clearing. They need a physical address with bit 43 set, and only a few paths produce one. The bench reaches them in two ways. One is the direct-mapped window with bit 40 set, which makes the sign extension set bit 43. The other is a lookup hit whose frame number puts a one in bit 43, with chosen bits 42:35 either all ones or mixed. Mode selection is reached by holding a kernel-only entry fixed and walking the privileged, alternate and current mode inputs.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

   typedef enum logic [2:0] {
      FLT_NONE  = 3'd0,
      FLT_ALIGN = 3'd1,
      FLT_ACV   = 3'd2,
      FLT_PAGE  = 3'd3,
      FLT_PMISS = 3'd4,
      FLT_NMISS = 3'd5,
      FLT_MCHK  = 3'd6,
      FLT_UNIMP = 3'd7
   } fault_e;

   typedef enum logic [1:0] {
      MD_KERN = 2'd0,
      MD_EXEC = 2'd1,
      MD_SUPV = 2'd2,
      MD_USER = 2'd3
   } mode_e;

   localparam int ST_W    = 6;
   localparam int ST_WR   = 0;
   localparam int ST_ACV  = 1;
   localparam int ST_BAD  = 2;
   localparam int ST_MISS = 3;
   localparam int ST_FONR = 4;
   localparam int ST_FONW = 5;

endpackage

// File: rtl/dtc_front.sv
// Alignment test and effective-mode selection.
module dtc_front #(
   parameter int VA_W   = 64,
   parameter int SIZE_W = 2,
   parameter int MODE_W = 2
) (
   input  logic [VA_W-1:0]   va_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic              priv_i,
   input  logic              alt_i,
   input  logic [MODE_W-1:0] cur_mode_i,
   input  logic [MODE_W-1:0] alt_mode_i,
   output logic              misalign_o,
   output logic [MODE_W-1:0] eff_mode_o
);
   localparam logic [VA_W-1:0] ONE = VA_W'(1);

   logic [VA_W-1:0] low_mask;

   always_comb begin
      low_mask   = (ONE << size_i) - ONE;
      misalign_o = |(va_i & low_mask);
      if (priv_i)
         eff_mode_o = alt_i ? alt_mode_i : MODE_W'(dtc_pkg::MD_KERN);
      else
         eff_mode_o = cur_mode_i;
   end
endmodule

// File: rtl/dtc_vclass.sv
// Classifies the upper virtual address bits: legal form and window hit.
module dtc_vclass #(
   parameter int          VA_W     = 64,
   parameter int          SIGN_BIT = 42,
   parameter int          SP_HI    = 47,
   parameter int          SP_LO    = 41,
   parameter logic [SP_HI-SP_LO:0] SP_TAG = '1
) (
   input  logic [VA_W-1:SP_LO] va_hi_i,
   output logic                va_ok_o,
   output logic                window_o
);
   localparam int EXT_W = VA_W - SIGN_BIT - 1;

   assign va_ok_o  = (va_hi_i[VA_W-1:SIGN_BIT+1] == {EXT_W{va_hi_i[SIGN_BIT]}});
   assign window_o = (va_hi_i[SP_HI:SP_LO] == SP_TAG);
endmodule

// File: rtl/dtc_perm.sv
// Hit-path address formation and per-mode permission decode.
module dtc_perm #(
   parameter int FULL_W     = 64,
   parameter int PPN_W      = 32,
   parameter int PAGE_SHIFT = 13,
   parameter int MODE_W     = 2,
   parameter int NMODE      = 4
) (
   input  logic [PPN_W-1:0]      ppn_i,
   input  logic [PAGE_SHIFT-1:0] offs_i,
   input  logic [MODE_W-1:0]     mode_i,
   input  logic                  write_i,
   input  logic [NMODE-1:0]      rd_en_i,
   input  logic [NMODE-1:0]      wr_en_i,
   input  logic                  fonr_i,
   input  logic                  fonw_i,
   output logic [FULL_W-1:0]     pa_o,
   output logic                  deny_o,
   output logic                  trap_o
);
   logic [NMODE-1:0] mode_oh;

   for (genvar g = 0; g < NMODE; g++) begin : g_dec
      assign mode_oh[g] = (mode_i == MODE_W'(g));
   end

   logic [NMODE-1:0] en_sel;
   assign en_sel = write_i ? wr_en_i : rd_en_i;
   assign deny_o = ~|(en_sel & mode_oh);
   assign trap_o = write_i ? fonw_i : fonr_i;
   assign pa_o   = (FULL_W'(ppn_i) << PAGE_SHIFT) + FULL_W'(offs_i);
endmodule

// File: rtl/dtc_phys.sv
// Physical width check and uncached / internal-register region handling.
module dtc_phys #(
   parameter int FULL_W  = 64,
   parameter int PA_W    = 44,
   parameter int UNC_BIT = 43,
   parameter int CLR_HI  = 42,
   parameter int CLR_LO  = 35
) (
   input  logic [FULL_W-1:0] pa_i,
   output logic              mchk_o,
   output logic              ireg_o,
   output logic              unc_o,
   output logic [PA_W-1:0]   pa_o
);
   localparam int CLR_N = CLR_HI - CLR_LO + 1;
   localparam logic [PA_W-1:0] CLR_MASK =
      PA_W'(((64'd1 << CLR_N) - 64'd1) << CLR_LO);

   logic [PA_W-1:0] pa_low;
   logic            unc_bit;

   assign pa_low  = pa_i[PA_W-1:0];
   assign unc_bit = pa_low[UNC_BIT];
   assign mchk_o  = |pa_i[FULL_W-1:PA_W];
   assign ireg_o  = unc_bit & (&pa_low[CLR_HI:CLR_LO]);
   assign unc_o   = unc_bit & ~ireg_o;
   assign pa_o    = unc_bit ? (pa_low & ~CLR_MASK) : pa_low;
endmodule

// File: rtl/dtc_xlate_check.sv
// Data-side translation checker: priority chain plus one output register.
module dtc_xlate_check #(
   parameter int VA_W       = 64,
   parameter int PA_W       = 44,
   parameter int PPN_W      = 32,
   parameter int PAGE_SHIFT = 13,
   parameter int SIZE_W     = 2,
   parameter int SIGN_BIT   = 42,
   parameter int SP_HI      = 47,
   parameter int SP_LO      = 41,
   parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e,
   parameter bit SP_SEXT    = 1'b1,
   parameter int SEXT_BIT   = 40,
   parameter int UNC_BIT    = 43,
   parameter int CLR_HI     = 42,
   parameter int CLR_LO     = 35
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [VA_W-1:0]   va_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic              write_i,
   input  logic              phys_i,
   input  logic              alt_i,
   input  logic              pte_i,
   input  logic              priv_i,
   input  logic [1:0]        cur_mode_i,
   input  logic [1:0]        alt_mode_i,
   input  logic              hit_i,
   input  logic [PPN_W-1:0]  ppn_i,
   input  logic [3:0]        rd_en_i,
   input  logic [3:0]        wr_en_i,
   input  logic              fonr_i,
   input  logic              fonw_i,
   output logic [PA_W-1:0]   pa_o,
   output logic              uncached_o,
   output logic [2:0]        fault_o,
   output logic [5:0]        status_o
);
   import dtc_pkg::*;

   localparam int MODE_W = 2;
   localparam int NMODE  = 1 << MODE_W;

   // elaboration-time parameter checks
   if (PA_W > VA_W) begin : g_chk_pa
      $error("PA_W must not exceed VA_W");
   end
   if (PPN_W + PAGE_SHIFT > VA_W) begin : g_chk_ppn
      $error("frame number plus page shift exceeds VA_W");
   end
   if (SP_LO > SIGN_BIT || SP_HI >= VA_W) begin : g_chk_win
      $error("window field must cover the sign bit and fit in VA_W");
   end
   if (UNC_BIT >= PA_W || CLR_HI >= UNC_BIT || CLR_LO > CLR_HI) begin : g_chk_unc
      $error("uncached bit and clear field must nest inside PA_W");
   end
   if (SEXT_BIT >= PA_W) begin : g_chk_sext
      $error("SEXT_BIT must lie inside PA_W");
   end

   // stage front
   logic              misalign;
   logic [MODE_W-1:0] eff_mode;

   dtc_front #(.VA_W(VA_W), .SIZE_W(SIZE_W), .MODE_W(MODE_W)) u_front (
      .va_i       (va_i),
      .size_i     (size_i),
      .priv_i     (priv_i),
      .alt_i      (alt_i),
      .cur_mode_i (cur_mode_i),
      .alt_mode_i (alt_mode_i),
      .misalign_o (misalign),
      .eff_mode_o (eff_mode)
   );

   logic va_ok, in_window;

   dtc_vclass #(
      .VA_W(VA_W), .SIGN_BIT(SIGN_BIT), .SP_HI(SP_HI), .SP_LO(SP_LO), .SP_TAG(SP_TAG)
   ) u_vclass (
      .va_hi_i  (va_i[VA_W-1:SP_LO]),
      .va_ok_o  (va_ok),
      .window_o (in_window)
   );

   logic [VA_W-1:0] tlb_pa;
   logic            deny, trap;

   dtc_perm #(
      .FULL_W(VA_W), .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT),
      .MODE_W(MODE_W), .NMODE(NMODE)
   ) u_perm (
      .ppn_i   (ppn_i),
      .offs_i  (va_i[PAGE_SHIFT-1:0]),
      .mode_i  (eff_mode),
      .write_i (write_i),
      .rd_en_i (rd_en_i),
      .wr_en_i (wr_en_i),
      .fonr_i  (fonr_i),
      .fonw_i  (fonw_i),
      .pa_o    (tlb_pa),
      .deny_o  (deny),
      .trap_o  (trap)
   );

   // direct-mapped window address, variant picked by SP_SEXT
   logic [PA_W-1:0] win_pa;
   localparam logic [PA_W-1:0] LO_MASK = PA_W'((64'd1 << SEXT_BIT) - 64'd1);

   if (SP_SEXT) begin : g_sext
      always_comb begin
         if (va_i[SEXT_BIT]) win_pa = va_i[PA_W-1:0] | ~LO_MASK;
         else                win_pa = va_i[PA_W-1:0] & LO_MASK;
      end
   end else begin : g_plain
      assign win_pa = va_i[PA_W-1:0];
   end

   // physical address selection and back-end checks
   logic [VA_W-1:0] pa_full;
   logic            mchk, ireg, unc;
   logic [PA_W-1:0] pa_fix;

   always_comb begin
      if (phys_i)         pa_full = va_i;
      else if (in_window) pa_full = VA_W'(win_pa);
      else                pa_full = tlb_pa;
   end

   dtc_phys #(
      .FULL_W(VA_W), .PA_W(PA_W), .UNC_BIT(UNC_BIT), .CLR_HI(CLR_HI), .CLR_LO(CLR_LO)
   ) u_phys (
      .pa_i   (pa_full),
      .mchk_o (mchk),
      .ireg_o (ireg),
      .unc_o  (unc),
      .pa_o   (pa_fix)
   );

   // priority chain
   fault_e          flt_n;
   logic [ST_W-1:0] st_n;
   logic            xlate;

   assign xlate = ~phys_i;

   always_comb begin
      flt_n = FLT_NONE;
      st_n  = '0;
      if (misalign) begin
         flt_n        = FLT_ALIGN;
         st_n[ST_WR]  = write_i;
      end else if (xlate && !va_ok) begin
         flt_n        = FLT_PAGE;
         st_n[ST_WR]  = write_i;
         st_n[ST_BAD] = 1'b1;
         st_n[ST_ACV] = 1'b1;
      end else if (xlate && in_window) begin
         if (cur_mode_i != MODE_W'(MD_KERN)) begin
            flt_n        = FLT_ACV;
            st_n[ST_WR]  = write_i;
            st_n[ST_ACV] = 1'b1;
         end
      end else if (xlate && !hit_i) begin
         flt_n         = pte_i ? FLT_PMISS : FLT_NMISS;
         st_n[ST_WR]   = write_i;
         st_n[ST_MISS] = 1'b1;
      end else if (xlate && deny) begin
         flt_n         = write_i ? FLT_PAGE : FLT_ACV;
         st_n[ST_WR]   = write_i;
         st_n[ST_ACV]  = 1'b1;
         st_n[ST_FONW] = write_i & fonw_i;
         st_n[ST_FONR] = ~write_i & fonr_i;
      end else if (xlate && trap) begin
         flt_n         = FLT_PAGE;
         st_n[ST_WR]   = write_i;
         st_n[ST_FONW] = write_i;
         st_n[ST_FONR] = ~write_i;
      end
      if (flt_n == FLT_NONE) begin
         if (mchk)      flt_n = FLT_MCHK;
         else if (ireg) flt_n = FLT_UNIMP;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pa_o       <= '0;
         uncached_o <= 1'b0;
         fault_o    <= FLT_NONE;
         status_o   <= '0;
      end else begin
         fault_o  <= flt_n;
         status_o <= st_n;
         if (flt_n == FLT_NONE) begin
            pa_o       <= pa_fix;
            uncached_o <= unc;
         end else begin
            pa_o       <= '0;
            uncached_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dtc_checker.sv
// Property checker bound to the translation checker.
module dtc_checker #(
   parameter int VA_W    = 64,
   parameter int PA_W    = 44,
   parameter int PPN_W   = 32,
   parameter int SIZE_W  = 2,
   parameter int UNC_BIT = 43,
   parameter int CLR_HI  = 42,
   parameter int CLR_LO  = 35
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [VA_W-1:0]   va_i,
   input logic [SIZE_W-1:0] size_i,
   input logic              write_i,
   input logic              phys_i,
   input logic              alt_i,
   input logic              pte_i,
   input logic              priv_i,
   input logic [1:0]        cur_mode_i,
   input logic [1:0]        alt_mode_i,
   input logic              hit_i,
   input logic [PPN_W-1:0]  ppn_i,
   input logic [3:0]        rd_en_i,
   input logic [3:0]        wr_en_i,
   input logic              fonr_i,
   input logic              fonw_i,
   input logic [PA_W-1:0]   pa_o,
   input logic              uncached_o,
   input logic [2:0]        fault_o,
   input logic [5:0]        status_o
);
   logic misal;
   assign misal = |(va_i & ((VA_W'(1) << size_i) - VA_W'(1)));

   AST_ALIGN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      misal |=> (fault_o == 3'd1 && status_o == {5'b0, $past(write_i)})); // R2

   AST_BYPASS_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!misal && phys_i && va_i[VA_W-1:UNC_BIT] == '0)
      |=> (fault_o == 3'd0 && pa_o == $past(va_i[PA_W-1:0]))); // R4

   AST_MISS_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_o == 3'd4 || fault_o == 3'd5) |-> (status_o[5:1] == 5'b00100)); // R8

   AST_MCHK_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_o == 3'd6 || fault_o == 3'd7) |-> (status_o == 6'd0)); // R12

   AST_UNC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uncached_o |-> (pa_o[UNC_BIT] && pa_o[CLR_HI:CLR_LO] == '0)); // R13

   AST_FAULT_NO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_o != 3'd0) |-> (pa_o == '0 && !uncached_o)); // R14
endmodule

bind dtc_xlate_check dtc_checker #(
   .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .SIZE_W(SIZE_W),
   .UNC_BIT(UNC_BIT), .CLR_HI(CLR_HI), .CLR_LO(CLR_LO)
) u_dtc_checker (.*);

// File: tb/test_dtc_xlate_check.sv
`timescale 1ns/100ps
module test_dtc_xlate_check;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [63:0] va_i;
   logic [1:0]  size_i;
   logic        write_i, phys_i, alt_i, pte_i, priv_i;
   logic [1:0]  cur_mode_i, alt_mode_i;
   logic        hit_i;
   logic [31:0] ppn_i;
   logic [3:0]  rd_en_i, wr_en_i;
   logic        fonr_i, fonw_i;
   logic [43:0] pa_o;
   logic        uncached_o;
   logic [2:0]  fault_o;
   logic [5:0]  status_o;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk_i = ~clk_i;

   dtc_xlate_check i_dtc_xlate_check (.*);

   task automatic idle();
      va_i = 64'h0; size_i = 2'd0; write_i = 0; phys_i = 0; alt_i = 0;
      pte_i = 0; priv_i = 0; cur_mode_i = 2'd0; alt_mode_i = 2'd0;
      hit_i = 0; ppn_i = 32'h0; rd_en_i = 4'h0; wr_en_i = 4'h0;
      fonr_i = 0; fonw_i = 0;
   endtask

   task automatic chk(string req, logic [2:0] ef, logic [5:0] es,
                      logic [43:0] ep, logic eu);
      n_vec++;
      if (fault_o !== ef || status_o !== es || pa_o !== ep || uncached_o !== eu) begin
         n_bad++;
         $display("FAIL %s: got fault=%0d status=%h pa=%h unc=%b, expected fault=%0d status=%h pa=%h unc=%b",
                  req, fault_o, status_o, pa_o, uncached_o, ef, es, ep, eu);
      end
   endtask

   // inputs are already set; result is registered on the next edge
   task automatic step(string req, logic [2:0] ef, logic [5:0] es,
                       logic [43:0] ep, logic eu);
      @(posedge clk_i); #1;
      chk(req, ef, es, ep, eu);
   endtask

   task automatic t_reset();
      idle();
      va_i = 64'h1234; phys_i = 1;
      repeat (3) @(posedge clk_i);
      #1 chk("R1 reset", 3'd0, 6'h00, 44'h0, 1'b0);
      rst_ni = 1'b1;
   endtask

   task automatic t_align();
      idle(); va_i = 64'h1002; size_i = 2'd2; write_i = 1; phys_i = 1;
      step("R2 misaligned store", 3'd1, 6'h01, 44'h0, 1'b0);
      idle(); va_i = 64'h8000_0000_0000_0001; size_i = 2'd1;
      step("R2 beats bad VA", 3'd1, 6'h00, 44'h0, 1'b0);
      idle(); va_i = 64'h1008; size_i = 2'd3; phys_i = 1;
      step("R2 aligned quad passes", 3'd0, 6'h00, 44'h1008, 1'b0);
   endtask

   task automatic t_bypass();
      idle(); va_i = 64'h1234_5678; phys_i = 1; hit_i = 0;
      step("R4 bypass ignores miss", 3'd0, 6'h00, 44'h1234_5678, 1'b0);
      idle(); va_i = 64'h0004_0000_0000_0000; phys_i = 1;
      step("R12 bypass wide address", 3'd6, 6'h00, 44'h0, 1'b0);
   endtask

   task automatic t_badva();
      idle(); va_i = 64'h0000_0800_0000_0000;
      step("R5 bad VA load", 3'd3, 6'h06, 44'h0, 1'b0);
      write_i = 1;
      step("R5 bad VA store", 3'd3, 6'h07, 44'h0, 1'b0);
   endtask

   task automatic t_window();
      idle(); va_i = 64'hFFFF_FC00_1234_5000;
      step("R7 window truncate", 3'd0, 6'h00, 44'h000_1234_5000, 1'b0);
      idle(); va_i = 64'hFFFF_FD00_0000_2000;
      step("R7 R13 window sign-ext uncached", 3'd0, 6'h00, 44'h800_0000_2000, 1'b1);
      idle(); va_i = 64'hFFFF_FDF8_0000_0000;
      step("R13 internal register space", 3'd7, 6'h00, 44'h0, 1'b0);
      idle(); va_i = 64'hFFFF_FC00_0000_0000; cur_mode_i = 2'd3;
      step("R6 window from user", 3'd2, 6'h02, 44'h0, 1'b0);
      write_i = 1; cur_mode_i = 2'd1; priv_i = 1; alt_i = 1; alt_mode_i = 2'd0;
      step("R6 window uses current mode", 3'd2, 6'h03, 44'h0, 1'b0);
   endtask

   task automatic t_miss();
      idle(); va_i = 64'h2000; pte_i = 1;
      step("R8 primary miss", 3'd4, 6'h08, 44'h0, 1'b0);
      pte_i = 0; write_i = 1;
      step("R8 normal miss store", 3'd5, 6'h09, 44'h0, 1'b0);
   endtask

   task automatic t_hit();
      idle(); va_i = 64'h3ABC; hit_i = 1; ppn_i = 32'h5;
      cur_mode_i = 2'd3; rd_en_i = 4'b1000;
      step("R9 hit load", 3'd0, 6'h00, 44'h0000_BABC, 1'b0);
      rd_en_i = 4'b0001; fonr_i = 1;
      step("R10 denied load trap", 3'd2, 6'h12, 44'h0, 1'b0);
      fonr_i = 0;
      step("R10 denied load", 3'd2, 6'h02, 44'h0, 1'b0);
      rd_en_i = 4'b1000; fonr_i = 1;
      step("R11 load trap", 3'd3, 6'h10, 44'h0, 1'b0);
      idle(); va_i = 64'h3ABC; hit_i = 1; ppn_i = 32'h5; write_i = 1;
      cur_mode_i = 2'd3; wr_en_i = 4'b0111; fonw_i = 1;
      step("R10 denied store trap", 3'd3, 6'h23, 44'h0, 1'b0);
      wr_en_i = 4'b1000;
      step("R11 store trap", 3'd3, 6'h21, 44'h0, 1'b0);
      fonw_i = 0;
      step("R9 hit store", 3'd0, 6'h00, 44'h0000_BABC, 1'b0);
   endtask

   task automatic t_mode();
      idle(); va_i = 64'h40; hit_i = 1; ppn_i = 32'h1; rd_en_i = 4'b0001;
      priv_i = 1; alt_i = 1; alt_mode_i = 2'd3; cur_mode_i = 2'd0;
      step("R3 alternate user denied", 3'd2, 6'h02, 44'h0, 1'b0);
      alt_i = 0; cur_mode_i = 2'd3;
      step("R3 privileged kernel", 3'd0, 6'h00, 44'h2040, 1'b0);
      priv_i = 0;
      step("R3 current user denied", 3'd2, 6'h02, 44'h0, 1'b0);
   endtask

   task automatic t_phys();
      idle(); va_i = 64'h100; hit_i = 1; rd_en_i = 4'b0001; ppn_i = 32'h8000_0000;
      step("R12 frame beyond width", 3'd6, 6'h00, 44'h0, 1'b0);
      ppn_i = 32'h4100_0000;
      step("R13 frame uncached", 3'd0, 6'h00, 44'h800_0000_0100, 1'b1);
      ppn_i = 32'h7FC0_0000;
      step("R13 frame register space", 3'd7, 6'h00, 44'h0, 1'b0);
      idle(); va_i = 64'h2000; size_i = 2'd3; pte_i = 1; write_i = 1;
      step("R14 fault clears pa", 3'd4, 6'h09, 44'h0, 1'b0);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      idle();
      #1;
      t_reset();
      t_align();
      t_bypass();
      t_badva();
      t_window();
      t_miss();
      t_hit();
      t_mode();
      t_phys();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule